// File: doc/BRIEF.md
# Recirculating Character Store with Cursor Reader

This block models a circular character memory in which a fixed number of character slots pass a single access port one after the other, the way a recirculating shift memory does. One slot carries a cursor tag. A reader gets a character only when the cursor slot is at the port and the reader is asking for data. Each character it takes moves the cursor one slot onward, so the following character is at the port on the next slot boundary. If the request is still high at that boundary, that character is taken too. Two characters are the most that one pass can deliver.

When the request is low at a boundary where the cursor is at the port, the cursor is released. It is not at the port again until the memory has made one full circulation. The circulation time is the number of slots times the slot time, and it sets the worst-case wait for an access. A write strobe given while the cursor is at the port replaces the character in the cursor slot and leaves the cursor where it is. A write strobe given at any other time is dropped.

Top module: `recirc_cursor_mem`

## Requirements
- R1: While reset is held and in the first cycle after it, charValid is 0, charOut is 0, cursorPos is 0 and curHere is 1. Every slot holds the value 0.
- R2: The port moves on by one slot every SLOT_CYCLES clock cycles, counting slot indices 0 to NUM_SLOTS-1 and then wrapping to 0. curHere is 1 exactly when the slot at the port is the cursor slot.
- R3: At a slot boundary where curHere is 1, reqIn is 1 and wrStb is 0, and fewer than two characters have been taken in a row, a character is taken. In the next cycle charValid is 1 for one cycle and charOut holds the character stored in the cursor slot.
- R4: Each take moves cursorPos on by one, modulo NUM_SLOTS (from NUM_SLOTS-1 it goes to 0). cursorPos changes at no other time.
- R5: A run of takes has at most two characters. At the third consecutive boundary with the cursor at the port, nothing is taken, even if reqIn is still 1.
- R6: A boundary where curHere is 1 and both reqIn and wrStb are 0 releases the cursor. No character is taken until the cursor reaches the port again NUM_SLOTS slot times later, even if reqIn rises in the meantime.
- R7: At a boundary where curHere is 1 and wrStb is 1, wrData replaces the character in the cursor slot. Nothing is taken and cursorPos does not change.
- R8: wrStb at a boundary where curHere is 0 changes no slot.
- R9: While no character is taken, curHere rises once every NUM_SLOTS*SLOT_CYCLES clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | 1 | Read request; holding it high takes characters when the cursor is at the port |
| wrStb | input | 1 | Write strobe for the cursor slot |
| wrData | input | CHAR_W | Character written on a write strobe |
| charValid | output | 1 | One-cycle pulse that marks a taken character |
| charOut | output | CHAR_W | Last character taken |
| cursorPos | output | $clog2(NUM_SLOTS) | Index of the slot that holds the cursor |
| curHere | output | 1 | High while the cursor slot is at the port |

## Verification
The bench fills all slots with distinct values through the write port. A read-back run then tells a correct slot write apart from a write to the wrong slot or a lost one. Several request patterns are applied: a request held for three boundaries, which tells a two-character run from an unbounded one; a request that drops for one boundary and comes back, which tells a released cursor from one that stays armed; and a write strobe away from the cursor, which shows whether writes are gated by the cursor position. A long random phase with a fixed seed mixes requests and writes and is compared every cycle against a bench model. This catches errors in slot timing, in when the cursor wraps, and in which of write and read wins when both are asked for at once.

// File: rtl/recirc_pkg.sv
package recirc_pkg;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic tick;   // slot boundary: the port moves to the next slot
    logic take;   // read the cursor slot and move the cursor on
    logic write;  // replace the cursor slot's character
  } slotStrobe_t;

endpackage

// File: rtl/recirc_ctrl.sv
module recirc_ctrl
  import recirc_pkg::*;
#(
  parameter int SLOT_CYCLES = 4,
  parameter int MAX_RUN     = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reqIn,
  input  logic        wrStb,
  input  logic        curHere,
  output slotStrobe_t strb
);

  localparam int RUN_W = $clog2(MAX_RUN + 1);

  logic             slotTick;
  logic [RUN_W-1:0] runCnt;

  // Slot timer: one boundary every SLOT_CYCLES cycles
  generate
    if (SLOT_CYCLES > 1) begin : g_div
      localparam int DIV_W = $clog2(SLOT_CYCLES);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          divCnt <= '0;
        end else if (divCnt == DIV_W'(SLOT_CYCLES - 1)) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign slotTick = (divCnt == DIV_W'(SLOT_CYCLES - 1));
    end else begin : g_nodiv
      assign slotTick = 1'b1;
    end
  endgenerate

  // If both are asked for, the write wins and the read waits a full pass
  always_comb begin
    strb.tick  = slotTick;
    strb.write = slotTick && curHere && wrStb;
    strb.take  = slotTick && curHere && !wrStb && reqIn &&
                 (runCnt < RUN_W'(MAX_RUN));
  end

  // Length of the current run; any boundary without a take ends it
  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (slotTick) begin
      runCnt <= strb.take ? runCnt + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/recirc_datapath.sv
module recirc_datapath
  import recirc_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CHAR_W    = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  slotStrobe_t                  strb,
  input  logic [CHAR_W-1:0]            wrData,
  output logic                         charValid,
  output logic [CHAR_W-1:0]            charOut,
  output logic [$clog2(NUM_SLOTS)-1:0] cursorPos,
  output logic                         curHere
);

  localparam int PTR_W = $clog2(NUM_SLOTS);

  function automatic logic [PTR_W-1:0] nextIdx(input logic [PTR_W-1:0] idx);
    return (idx == PTR_W'(NUM_SLOTS - 1)) ? '0 : idx + 1'b1;
  endfunction

  logic [CHAR_W-1:0] slotMem [NUM_SLOTS];
  logic [PTR_W-1:0]  portIdx;
  logic [PTR_W-1:0]  cursorIdx;

  // The store is kept as a ring addressed by where the port is, which
  // behaves the same as shifting every slot each boundary
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) slotMem[i] <= '0;
    end else if (strb.write) begin
      slotMem[cursorIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      portIdx   <= '0;
      cursorIdx <= '0;
      charValid <= 1'b0;
      charOut   <= '0;
    end else begin
      charValid <= strb.take;
      if (strb.tick) portIdx <= nextIdx(portIdx);
      if (strb.take) begin
        charOut   <= slotMem[cursorIdx];
        cursorIdx <= nextIdx(cursorIdx);
      end
    end
  end

  assign curHere   = (portIdx == cursorIdx);
  assign cursorPos = cursorIdx;

endmodule

// File: rtl/recirc_cursor_mem.sv
module recirc_cursor_mem
  import recirc_pkg::*;
#(
  parameter int NUM_SLOTS   = 16,
  parameter int CHAR_W      = 7,
  parameter int SLOT_CYCLES = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reqIn,
  input  logic                         wrStb,
  input  logic [CHAR_W-1:0]            wrData,
  output logic                         charValid,
  output logic [CHAR_W-1:0]            charOut,
  output logic [$clog2(NUM_SLOTS)-1:0] cursorPos,
  output logic                         curHere
);

  slotStrobe_t strb;

  recirc_ctrl #(
    .SLOT_CYCLES(SLOT_CYCLES),
    .MAX_RUN    (2)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .reqIn  (reqIn),
    .wrStb  (wrStb),
    .curHere(curHere),
    .strb   (strb)
  );

  recirc_datapath #(
    .NUM_SLOTS(NUM_SLOTS),
    .CHAR_W   (CHAR_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .wrData   (wrData),
    .charValid(charValid),
    .charOut  (charOut),
    .cursorPos(cursorPos),
    .curHere  (curHere)
  );

endmodule

// File: rtl/recirc_cursor_mem_chk.sv
module recirc_cursor_mem_chk
  import recirc_pkg::*;
#(
  parameter int NUM_SLOTS   = 16,
  parameter int SLOT_CYCLES = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         reqIn,
  input logic                         wrStb,
  input logic                         charValid,
  input logic [$clog2(NUM_SLOTS)-1:0] cursorPos,
  input logic                         curHere,
  input slotStrobe_t                  strb
);

  // Cycles since the last take pulse (saturating) and the length of the run
  int gap;
  int runLen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap    <= SLOT_CYCLES;
      runLen <= 0;
    end else if (charValid) begin
      runLen <= (gap == SLOT_CYCLES - 1) ? runLen + 1 : 1;
      gap    <= 0;
    end else if (gap < SLOT_CYCLES) begin
      gap <= gap + 1;
    end
  end

  a_r3_take_needs_cursor: assert property (@(posedge clk) disable iff (rst)
    charValid |-> $past(reqIn && curHere && !wrStb && strb.tick));

  a_r4_cursor_steps_one: assert property (@(posedge clk) disable iff (rst)
    !$stable(cursorPos) |->
      (charValid && (int'(cursorPos) == (int'($past(cursorPos)) + 1) % NUM_SLOTS)));

  a_r5_run_limit: assert property (@(posedge clk) disable iff (rst)
    (charValid && gap == SLOT_CYCLES - 1) |-> (runLen < 2));

  a_r6_no_request_no_take: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && curHere && !reqIn) |=> !charValid);

  a_r7_write_keeps_cursor: assert property (@(posedge clk) disable iff (rst)
    (strb.tick && curHere && wrStb) |=> (!charValid && $stable(cursorPos)));

endmodule

bind recirc_cursor_mem recirc_cursor_mem_chk #(
  .NUM_SLOTS  (NUM_SLOTS),
  .SLOT_CYCLES(SLOT_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqIn    (reqIn),
  .wrStb    (wrStb),
  .charValid(charValid),
  .cursorPos(cursorPos),
  .curHere  (curHere),
  .strb     (strb)
);

// File: tb/recirc_cursor_mem_bench.sv
`timescale 1ns/1ps
module recirc_cursor_mem_bench;

  localparam int N  = 16;
  localparam int CW = 7;
  localparam int SC = 4;
  localparam int PW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqIn = 1'b0;
  logic          wrStb = 1'b0;
  logic [CW-1:0] wrData = '0;
  logic          charValid;
  logic [CW-1:0] charOut;
  logic [PW-1:0] cursorPos;
  logic          curHere;

  always #4 clk = ~clk;

  recirc_cursor_mem #(.NUM_SLOTS(N), .CHAR_W(CW), .SLOT_CYCLES(SC)) u_recirc_cursor_mem (
    .clk(clk), .rst(rst), .reqIn(reqIn), .wrStb(wrStb), .wrData(wrData),
    .charValid(charValid), .charOut(charOut), .cursorPos(cursorPos), .curHere(curHere)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  string phase   = "R3";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] fillVal(input int k);
    return CW'((k * 37 + 5) % 128);
  endfunction

  // Bench model of the requirements
  int          mDiv, mPort, mCur, mRun;
  logic        mValid;
  logic [CW-1:0] mChar;
  logic [CW-1:0] mMem [N];

  always @(posedge clk) begin
    if (rst) begin
      mDiv <= 0; mPort <= 0; mCur <= 0; mRun <= 0;
      mValid <= 1'b0; mChar <= '0;
      for (int i = 0; i < N; i++) mMem[i] <= '0;
    end else begin
      mValid <= 1'b0;
      if (mDiv == SC - 1) begin
        mDiv  <= 0;
        mPort <= (mPort + 1) % N;
        if (mPort == mCur && wrStb) begin
          mMem[mCur] <= wrData;
          mRun <= 0;
        end else if (mPort == mCur && reqIn && mRun < 2) begin
          mValid <= 1'b1;
          mChar  <= mMem[mCur];
          mCur   <= (mCur + 1) % N;
          mRun   <= mRun + 1;
        end else begin
          mRun <= 0;
        end
      end else begin
        mDiv <= mDiv + 1;
      end
    end
  end

  int          takeCnt = 0;
  int          wrapCnt = 0;
  logic [CW-1:0] lastChar;
  int          prevCur = 0;

  // One clock; compare at the falling edge
  task automatic cyc();
    @(negedge clk);
    chk(charValid == mValid, {phase, " charValid"}, charValid, mValid);
    if (mValid) chk(charOut == mChar, {phase, " charOut"}, charOut, mChar);
    chk(int'(cursorPos) == mCur, "R4 cursorPos", cursorPos, mCur);
    chk(curHere == (mPort == mCur), "R2 curHere", curHere, mPort == mCur);
    if (charValid) begin
      takeCnt++;
      lastChar = charOut;
      chk(int'(cursorPos) == (prevCur + 1) % N, "R4 step", cursorPos, (prevCur + 1) % N);
      if (cursorPos == '0) wrapCnt++;
    end
    prevCur = int'(cursorPos);
  endtask

  task automatic waitHereRise();
    logic prev;
    do begin
      prev = curHere;
      cyc();
    end while (!(curHere && !prev));
  endtask

  task automatic mainFlow();
    int base, cnt;
    logic [CW-1:0] want;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state in the first cycle after reset
    @(negedge clk);
    chk(charValid == 1'b0, "R1 charValid", charValid, 0);
    chk(charOut == '0, "R1 charOut", charOut, 0);
    chk(cursorPos == '0, "R1 cursorPos", cursorPos, 0);
    chk(curHere == 1'b1, "R1 curHere", curHere, 1);
    // R1: the first slot holds 0 when read straight after reset
    phase = "R1";
    reqIn = 1'b1;
    base = takeCnt;
    repeat (SC) cyc();
    reqIn = 1'b0;
    chk(takeCnt == base + 1, "R1 take count", takeCnt - base, 1);
    chk(lastChar == '0, "R1 slot0 zero", lastChar, 0);

    // R7: fill every slot through the write port, then read it back
    for (int k = 0; k < N; k++) begin
      int slot;
      phase = "R7";
      waitHereRise();
      slot = int'(cursorPos);
      wrStb = 1'b1; wrData = fillVal(slot);
      base = takeCnt;
      repeat (SC) cyc();
      wrStb = 1'b0;
      chk(takeCnt == base, "R7 no take on write", takeCnt - base, 0);
      chk(int'(cursorPos) == slot, "R7 cursor held", cursorPos, slot);
      waitHereRise();
      reqIn = 1'b1;
      repeat (SC) cyc();
      reqIn = 1'b0;
      chk(lastChar == fillVal(slot), "R7 readback", lastChar, fillVal(slot));
    end
    chk(wrapCnt >= 1, "R4 wrap seen", wrapCnt, 1);

    // R5: request held over three boundaries gives two characters
    phase = "R5";
    waitHereRise();
    base = takeCnt;
    want = fillVal((int'(cursorPos) + 1) % N);
    reqIn = 1'b1;
    repeat (3 * SC) cyc();
    reqIn = 1'b0;
    chk(takeCnt == base + 2, "R5 run of two", takeCnt - base, 2);
    chk(lastChar == want, "R5 second char", lastChar, want);

    // R6: one take, released for one boundary, then request back high
    phase = "R6";
    waitHereRise();
    base = takeCnt;
    reqIn = 1'b1;
    repeat (SC) cyc();
    reqIn = 1'b0;
    repeat (SC) cyc();
    reqIn = 1'b1;
    repeat ((N - 1) * SC) cyc();
    reqIn = 1'b0;
    chk(takeCnt == base + 1, "R6 released cursor", takeCnt - base, 1);

    // R9: circulation period with no takes
    phase = "R9";
    waitHereRise();
    cnt = 0;
    begin
      logic prev;
      do begin
        prev = curHere;
        cyc();
        cnt++;
      end while (!(curHere && !prev));
    end
    chk(cnt == N * SC, "R9 period", cnt, N * SC);

    // R8: write strobe while the cursor is away changes nothing
    phase = "R8";
    waitHereRise();
    repeat (SC) cyc();
    wrStb = 1'b1; wrData = 7'h2A;
    repeat (SC) cyc();
    wrStb = 1'b0;
    want = fillVal(int'(cursorPos));
    waitHereRise();
    reqIn = 1'b1;
    repeat (SC) cyc();
    reqIn = 1'b0;
    chk(lastChar == want, "R8 slot unchanged", lastChar, want);

    // Random phase checked against the model (R2, R3, R4, R5, R6, R7)
    phase = "R3 random";
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4000; i++) begin
      reqIn  = ($urandom % 10) < 6;
      wrStb  = ($urandom % 10) == 0;
      wrData = CW'($urandom);
      cyc();
    end
    reqIn = 1'b0; wrStb = 1'b0;
    repeat (4) cyc();
  endtask

  initial begin
    fork
      mainFlow();
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule